// File: doc/BRIEF.md
# Four-Lane Flush-to-Zero Float Comparator

The block compares two 128-bit vectors lane by lane. Each vector carries four 32-bit single-precision patterns. For each lane it produces a mask word that is all ones when the selected condition holds and all zeros when it does not. A 2-bit operation code selects one of four conditions: signed greater-than, equality, greater magnitude or equal magnitude.

The comparison works on the raw bit patterns. Any value whose exponent field is zero counts as zero of either sign, so signed zeros and denormals compare as the same value. No special handling is applied to NaN or infinity patterns, and no exception flags are produced. Ordering uses an integer comparison of the sign-magnitude patterns.

One register stage follows the compare logic. It captures a result only when the input is qualified by valid_i, and it presents a matching valid_o one cycle later. A vector-unit pipeline uses the block to build select masks for blend and branch-on-compare operations.

Top module: `fz_vec_cmp`

## Requirements
- R1: A lane value counts as zero when bits 30..23 of its pattern (the exponent field) are all zero. Both signed zeros and every denormal pattern count as zero.
- R2: Lane k occupies bits 32k+31..32k of a_i, b_i and mask_o, with lane 0 at bits 31..0. Each mask lane is either 32'hFFFFFFFF (pass) or 32'h00000000 (fail), and each lane is decided only from its own a and b lanes.
- R3: With op_i = 2'b01 (equal), a lane passes when the a and b patterns are identical, or when both count as zero.
- R4: With op_i = 2'b11 (magnitude equal), a lane passes when bits 30..0 of a and b match, or when both count as zero.
- R5: With op_i = 2'b10 (magnitude greater), a lane fails whenever a counts as zero. Otherwise it passes when b counts as zero, or when bits 30..0 of a are larger than those of b as an unsigned number.
- R6: With op_i = 2'b00 (greater), if a counts as zero the lane passes only when b is a negative normal (b at least 32'h80800000 unsigned). If b counts as zero and a does not, the lane passes only when a is positive (bit 31 clear).
- R7: With op_i = 2'b00 and neither value counting as zero, a negative a passes only when b is also negative and a's pattern is smaller unsigned. A positive a passes when b is negative or a's pattern is larger unsigned.
- R8: After reset, valid_o and mask_o are zero. An operation presented with valid_i high at one rising edge shows its mask on mask_o, with valid_o high, from that edge until the next edge. valid_o is low after any edge where valid_i was low.
- R9: After an edge where valid_i is low, mask_o keeps its previous value, whatever op_i, a_i and b_i carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Qualifies op_i, a_i and b_i in this cycle |
| op_i | input | 2 | Condition select: 00 greater, 01 equal, 10 magnitude greater, 11 magnitude equal |
| a_i | input | 128 | Left operand vector, four 32-bit lanes |
| b_i | input | 128 | Right operand vector, four 32-bit lanes |
| valid_o | output | 1 | mask_o holds a new result |
| mask_o | output | 128 | Per-lane all-ones or all-zeros result |

## Verification
Two functions can meet in one cycle: flushing an operand to zero and ordering it against a signed or unsigned value. A single vector can place a denormal in one lane beside a negative normal, a signed-zero pair or a large magnitude in the others. The bench builds such vectors on purpose, both directly and as a weighted random mix with many exponent-zero patterns and sign-flipped copies. A scoreboard judges every lane against an independent model, which maps each value to a signed integer key that is zero for the flushed range. The bench also interleaves back-to-back operations with idle gaps, so it can check that a result is captured or held on the right edges.

// File: rtl/fz_cmp_pkg.sv
package fz_cmp_pkg;

  localparam int unsigned LANE_W   = 32;
  localparam int unsigned EXP_LSB  = 23;
  localparam int unsigned EXP_W    = 8;
  localparam int unsigned MAG_W    = LANE_W - 1;
  localparam int unsigned OP_W     = 2;

  typedef enum logic [OP_W-1:0] {
    OP_GT  = 2'b00,
    OP_EQ  = 2'b01,
    OP_MGT = 2'b10,
    OP_MEQ = 2'b11
  } cmp_op_e;

  typedef struct packed {
    logic             sign;
    logic             zero;
    logic [MAG_W-1:0] mag;
  } lane_info_t;

endpackage

// File: rtl/fz_lane_class.sv
module fz_lane_class
  import fz_cmp_pkg::*;
(
  input  logic [LANE_W-1:0] val_i,
  output lane_info_t        info_o
);

  always_comb begin
    info_o.sign = val_i[LANE_W-1];
    info_o.mag  = val_i[MAG_W-1:0];
    // flushed range: exponent field all zero
    info_o.zero = ~|val_i[EXP_LSB +: EXP_W];
  end

endmodule

// File: rtl/fz_lane_eval.sv
module fz_lane_eval
  import fz_cmp_pkg::*;
(
  input  logic [OP_W-1:0]   op_i,
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  output logic              hit_o
);

  lane_info_t a_inf, b_inf;
  logic gt_hit, eq_hit, mgt_hit, meq_hit;
  logic both_zero;

  fz_lane_class i_cls_a (.val_i(a_i), .info_o(a_inf));
  fz_lane_class i_cls_b (.val_i(b_i), .info_o(b_inf));

  assign both_zero = a_inf.zero & b_inf.zero;

  always_comb begin
    eq_hit  = (a_i == b_i) | both_zero;
    meq_hit = (a_inf.mag == b_inf.mag) | both_zero;
    mgt_hit = ~a_inf.zero & (b_inf.zero | (a_inf.mag > b_inf.mag));

    if (a_inf.zero)
      gt_hit = b_inf.sign & ~b_inf.zero;
    else if (b_inf.zero)
      gt_hit = ~a_inf.sign;
    else if (a_inf.sign)
      gt_hit = b_inf.sign & (a_i < b_i);
    else
      gt_hit = b_inf.sign | (a_i > b_i);
  end

  always_comb begin
    unique case (cmp_op_e'(op_i))
      OP_GT:   hit_o = gt_hit;
      OP_EQ:   hit_o = eq_hit;
      OP_MGT:  hit_o = mgt_hit;
      OP_MEQ:  hit_o = meq_hit;
      default: hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/fz_out_stage.sv
module fz_out_stage #(
  parameter int unsigned W       = 128,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);

  if (REG_OUT) begin : g_reg
    logic         vld_q;
    logic [W-1:0] data_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q  <= 1'b0;
        data_q <= '0;
      end else begin
        vld_q <= valid_i;
        if (valid_i) data_q <= data_i;
      end
    end

    assign valid_o = vld_q;
    assign data_o  = data_q;
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign valid_o    = valid_i;
    assign data_o     = data_i;
  end

endmodule

// File: rtl/fz_vec_cmp.sv
module fz_vec_cmp
  import fz_cmp_pkg::*;
#(
  parameter int unsigned LANES   = 4,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned VEC_W  = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] mask_o
);

  logic [LANES-1:0] lane_hit;
  logic [VEC_W-1:0] mask_d;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    fz_lane_eval i_eval (
      .op_i (op_i),
      .a_i  (a_i[l*LANE_W +: LANE_W]),
      .b_i  (b_i[l*LANE_W +: LANE_W]),
      .hit_o(lane_hit[l])
    );
    assign mask_d[l*LANE_W +: LANE_W] = {LANE_W{lane_hit[l]}};
  end

  fz_out_stage #(
    .W      (VEC_W),
    .REG_OUT(REG_OUT)
  ) i_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .data_i (mask_d),
    .valid_o(valid_o),
    .data_o (mask_o)
  );

endmodule

// File: rtl/fz_vec_cmp_chk.sv
module fz_vec_cmp_chk
  import fz_cmp_pkg::*;
#(
  parameter int unsigned LANES   = 4,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned VEC_W  = LANES * LANE_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [OP_W-1:0]  op_i,
  input logic [VEC_W-1:0] a_i,
  input logic [VEC_W-1:0] b_i,
  input logic             valid_o,
  input logic [VEC_W-1:0] mask_o
);

  if (REG_OUT) begin : g_chk
    assert_valid_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);
    assert_idle_no_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !valid_o);
    assert_mask_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(mask_o));

    for (genvar l = 0; l < LANES; l++) begin : g_l
      assert_lane_uniform_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($countones(mask_o[l*LANE_W +: LANE_W]) == 0) ||
        ($countones(mask_o[l*LANE_W +: LANE_W]) == LANE_W));
      assert_eq_identical_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && op_i == OP_EQ && a_i[l*LANE_W +: LANE_W] == b_i[l*LANE_W +: LANE_W])
        |=> &mask_o[l*LANE_W +: LANE_W]);
      assert_meq_same_mag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && op_i == OP_MEQ &&
         a_i[l*LANE_W +: MAG_W] == b_i[l*LANE_W +: MAG_W])
        |=> &mask_o[l*LANE_W +: LANE_W]);
      assert_mgt_zero_a_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && op_i == OP_MGT && a_i[l*LANE_W + EXP_LSB +: EXP_W] == '0)
        |=> ~|mask_o[l*LANE_W +: LANE_W]);
      assert_gt_zero_pair_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && op_i == OP_GT && a_i[l*LANE_W + EXP_LSB +: EXP_W] == '0 &&
         b_i[l*LANE_W + EXP_LSB +: EXP_W] == '0)
        |=> ~|mask_o[l*LANE_W +: LANE_W]);
    end
  end

endmodule

bind fz_vec_cmp fz_vec_cmp_chk #(
  .LANES  (LANES),
  .REG_OUT(REG_OUT)
) i_fz_vec_cmp_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .op_i   (op_i),
  .a_i    (a_i),
  .b_i    (b_i),
  .valid_o(valid_o),
  .mask_o (mask_o)
);

// File: tb/test_fz_vec_cmp.sv
`timescale 1ns/1ps
module test_fz_vec_cmp;

  localparam int LANES = 4;
  localparam int VW    = LANES * 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [1:0]    op_i = '0;
  logic [VW-1:0] a_i = '0;
  logic [VW-1:0] b_i = '0;
  logic          valid_o;
  logic [VW-1:0] mask_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [VW-1:0] exp_q[$];
  string         tag_q[$];
  logic [VW-1:0] last_mask = '0;

  always #2 clk_i = ~clk_i;

  fz_vec_cmp i_fz_vec_cmp (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .mask_o(mask_o)
  );

  // signed key: flushed range maps to 0, else sign-magnitude as integer
  function automatic longint key_of(logic [31:0] v);
    if (v[30:23] == 8'h00) return 0;
    return v[31] ? -longint'(v[30:0]) : longint'(v[30:0]);
  endfunction

  function automatic longint absl(longint x);
    return (x < 0) ? -x : x;
  endfunction

  function automatic logic [VW-1:0] model(logic [1:0] op, logic [VW-1:0] a, logic [VW-1:0] b);
    logic [VW-1:0] m;
    for (int l = 0; l < LANES; l++) begin
      longint ka = key_of(a[l*32 +: 32]);
      longint kb = key_of(b[l*32 +: 32]);
      bit p;
      case (op)
        2'b00:   p = ka > kb;
        2'b01:   p = ka == kb;
        2'b10:   p = absl(ka) > absl(kb);
        default: p = absl(ka) == absl(kb);
      endcase
      m[l*32 +: 32] = {32{p}};
    end
    return m;
  endfunction

  task automatic check(bit ok, string tag, logic [VW-1:0] act, logic [VW-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic issue(logic [1:0] op, logic [VW-1:0] a, logic [VW-1:0] b, string tag);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; a_i = a; b_i = b;
    exp_q.push_back(model(op, a, b));
    tag_q.push_back(tag);
  endtask

  // idle cycles with garbage on the data inputs (R9)
  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0; op_i = 2'($urandom); a_i = {4{$urandom}}; b_i = {4{$urandom}};
    end
  endtask

  // monitor / scoreboard
  always @(posedge clk_i) begin
    logic v_in;
    v_in = valid_i;
    #1;
    if (rst_ni && !done) begin
      check(valid_o == v_in, "R8 valid_o latency", {127'd0, valid_o}, {127'd0, v_in});
      if (valid_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected result", mask_o, '0);
        end else begin
          logic [VW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(mask_o === e, t, mask_o, e);
          last_mask = e;
        end
      end else begin
        check(mask_o === last_mask, "R9 mask hold while idle", mask_o, last_mask);
      end
    end
  end

  function automatic logic [31:0] rand_val();
    logic s;
    s = 1'($urandom);
    case ($urandom % 6)
      0:       return {s, 8'h00, 23'($urandom)};
      1:       return {s, 8'($urandom % 254 + 1), 23'($urandom)};
      2:       return {s, 8'hFF, 23'($urandom)};
      3:       return {s, 8'h01, 23'($urandom % 4)};
      4:       return {s, 8'h00, 23'h0};
      default: return {s, 8'h80, 23'($urandom % 4)};
    endcase
  endfunction

  localparam logic [31:0] PZ  = 32'h0000_0000, NZ  = 32'h8000_0000;
  localparam logic [31:0] PD  = 32'h0000_0001, ND  = 32'h807F_FFFF;
  localparam logic [31:0] PN  = 32'h0080_0000, NN  = 32'h8080_0000;
  localparam logic [31:0] ONE = 32'h3F80_0000, TWO = 32'h4000_0000;
  localparam logic [31:0] M1  = 32'hBF80_0000, M2  = 32'hC000_0000;

  initial begin
    #1;
    check(valid_o === 1'b0 && mask_o === '0, "R8 reset state", mask_o, '0);
    #9 rst_ni = 1'b1;
    @(negedge clk_i);

    // R1/R6: zero-ish a against negative normal, zeros, positive normal
    issue(2'b00, {PD, NZ, PZ, ND}, {NN, NN, PN, NZ}, "R6 gt with flushed a");
    // R6: b flushed, a normal of either sign
    issue(2'b00, {ONE, M1, PN, NN}, {PD, ND, NZ, PZ}, "R6 gt with flushed b");
    // R7: both nonzero, all sign combinations
    issue(2'b00, {TWO, ONE, M1, M2}, {ONE, TWO, M2, M1}, "R7 gt both nonzero");
    issue(2'b00, {ONE, M1, ONE, M1}, {M1, ONE, ONE, M1}, "R7 gt mixed signs");
    // R3: equal with signed zeros and denormals
    issue(2'b01, {PZ, PD, ONE, ONE}, {NZ, ND, ONE, M1}, "R3 equal");
    issue(2'b01, {PN, NN, PD, TWO}, {PD, PN, PZ, TWO}, "R3 equal near normal boundary");
    // R4: magnitude equal
    issue(2'b11, {ONE, PD, TWO, NN}, {M1, NZ, ONE, PN}, "R4 magnitude equal");
    // R5: magnitude greater
    issue(2'b10, {PD, M2, ONE, NN}, {NN, ONE, M2, ND}, "R5 magnitude greater");
    issue(2'b10, {PZ, PN, M1, TWO}, {PZ, NZ, ONE, M2}, "R5 magnitude greater ties");
    idle(2);
    // R2: lane isolation, same lanes in different slots
    issue(2'b00, {PZ, PZ, PZ, ONE}, {PZ, PZ, PZ, PZ}, "R2 lane 0 alone");
    issue(2'b00, {ONE, PZ, PZ, PZ}, {PZ, PZ, PZ, PZ}, "R2 lane 3 alone");
    idle(3);
    // R1: extreme exponent patterns pass through ordering without special cases
    issue(2'b00, {32'h7F80_0000, 32'h7FFF_FFFF, 32'hFF80_0000, 32'h0080_0001},
                 {32'h7F7F_FFFF, 32'h7F80_0000, 32'hFF7F_FFFF, 32'h0080_0000}, "R1 raw extremes");

    for (int i = 0; i < 400; i++) begin
      logic [VW-1:0] a, b;
      for (int l = 0; l < LANES; l++) begin
        a[l*32 +: 32] = rand_val();
        case ($urandom % 4)
          0:       b[l*32 +: 32] = a[l*32 +: 32];
          1:       b[l*32 +: 32] = a[l*32 +: 32] ^ 32'h8000_0000;
          default: b[l*32 +: 32] = rand_val();
        endcase
      end
      issue(2'($urandom), a, b, "R2 R3 R4 R5 R6 R7 random mix");
      if ($urandom % 5 == 0) idle(1 + $urandom % 2);
    end
    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R8 results missing actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule